// File: doc/BRIEF.md
# Masked Priority Interrupt Level Controller

This block collects level-sensitive hardware interrupt lines, per-processor software interrupts and per-processor tick requests. It reduces them to one 4-bit interrupt level per processor. Every hardware source has its own bit in a 32-bit mask, where a set bit blocks the source. Software never rewrites the mask as a whole. It sets bits through one register address and clears bits through another, so two agents can change different bits without a read-modify-write race. Mask bit 31 is a master gate that silences everything while it is set.

Each source has a fixed processor level, and several sources may share one level. The four asynchronous error sources sit at level 15 and reach every processor. All other hardware sources reach only the processor named by a target-select register. The level of each processor is registered. One cycle after its inputs settle, it holds the highest active, unmasked request, or 0 when there is none. A raw pending register lets software see which lines are asserted, whatever the mask holds.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, the target reads 0, every software register reads 0 and every level output is 0.
- R2: A write to address 1 sets the mask bits where the write data holds ones; zero bits leave them unchanged. Addresses 1 and 2 both read the mask.
- R3: A write to address 2 clears the mask bits where the write data holds ones; zero bits leave them unchanged.
- R4: While mask bit 31 is set, every level output is 0, whatever the hardware, software and tick requests are.
- R5: Address 0 reads the raw hardware lines in bits 30..0, whatever the mask holds, with bit 31 reading 0.
- R6: Onboard sources map to these levels: bit 18 to 4, bit 16 to 6, bit 20 to 8, bit 21 to 9, bit 19 to 10, bit 22 to 11, bits 15 and 14 to 12, and bit 17 to 13.
- R7: Expansion-bus level n (1..7) sits at bit n+6, and second-bus level n sits at bit n-1. Both map n = 1..7 to levels 2, 3, 5, 7, 9, 11 and 13.
- R8: Error bits 30..27 map to level 15 and drive every processor, whatever the target.
- R9: For processor c, a write to address 4+2c sets software bits 15..1, and a write to address 5+2c clears them. Both addresses read those bits. Bit 0 always reads 0. Software bit n raises level n on processor c only.
- R10: The tick input of processor c raises level 14 on that processor only. Only mask bit 31 gates it.
- R11: Address 3 holds the target. Non-error hardware sources reach only the target processor. A write with a value of NCPU or more leaves the target unchanged.
- R12: Each level output is registered. One clock edge after the inputs, it equals the highest unmasked active level. Hardware requests are not latched, so a request goes away once its line drops.
- R13: Hardware bits 26..23 have no level and never raise an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_src | input | 31 | Level-sensitive hardware request lines |
| cpu_tick | input | NCPU | Per-processor tick requests (level 14) |
| addr | input | AW | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational, 0 when rd_en is low |
| irl | output | 4*NCPU | Interrupt level per processor, processor c in bits 4c+3..4c |

## Verification
The hardest case is a non-error source that sits at the same level as a software interrupt on the processor that is not the target, while the target is changing. Only that processor's output shows whether routing and merging are both right. The stimulus first walks each hardware bit alone and checks the level on both processors. It then moves the target and sets software bits on processor 1. A long random phase follows in which writes to every register land while the hardware lines change every cycle. A reference model checks both outputs on every edge.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NCPU = 2,
  localparam int AW = $clog2(4 + 2 * NCPU),
  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [30:0]       hw_src,
  input  logic [NCPU-1:0]   cpu_tick,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic [4*NCPU-1:0] irl
);

  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_MSET = AW'(1);
  localparam logic [AW-1:0] A_MCLR = AW'(2);
  localparam logic [AW-1:0] A_TGT  = AW'(3);

  logic [31:0]            mask_q;
  logic [TW-1:0]          target_q;
  logic [NCPU-1:0][15:0]  soft_q;
  logic [30:0]            live;

  function automatic logic [3:0] bus_lvl(input int n);
    return (n == 1) ? 4'd2 : 4'(2 * n - 1);
  endfunction

  function automatic logic [3:0] src_lvl(input int i);
    case (i)
      30, 29, 28, 27: return 4'd15;
      22:             return 4'd11;
      21:             return 4'd9;
      20:             return 4'd8;
      19:             return 4'd10;
      18:             return 4'd4;
      17:             return 4'd13;
      16:             return 4'd6;
      15, 14:         return 4'd12;
      default: begin
        if (i <= 6)       return bus_lvl(i + 1);
        else if (i <= 13) return bus_lvl(i - 6);
        else              return 4'd0;
      end
    endcase
  endfunction

  assign live = mask_q[31] ? 31'd0 : (hw_src & ~mask_q[30:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      target_q <= '0;
      soft_q   <= '0;
    end else if (wr_en) begin
      if (addr == A_MSET) mask_q <= mask_q | wdata;
      if (addr == A_MCLR) mask_q <= mask_q & ~wdata;
      if (addr == A_TGT && wdata < 32'(NCPU)) target_q <= TW'(wdata);
      for (int c = 0; c < NCPU; c++) begin
        if (addr == AW'(4 + 2 * c)) soft_q[c] <= soft_q[c] | {wdata[15:1], 1'b0};
        if (addr == AW'(5 + 2 * c)) soft_q[c] <= soft_q[c] & ~{wdata[15:1], 1'b0};
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_PEND) rdata = {1'b0, hw_src};
      if (addr == A_MSET || addr == A_MCLR) rdata = mask_q;
      if (addr == A_TGT) rdata = 32'(target_q);
      for (int c = 0; c < NCPU; c++)
        if (addr == AW'(4 + 2 * c) || addr == AW'(5 + 2 * c)) rdata = {16'd0, soft_q[c]};
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [15:0] req;
    logic [3:0]  top;

    always_comb begin
      req = '0;
      if (!mask_q[31]) begin
        req = soft_q[c];
        if (cpu_tick[c]) req[14] = 1'b1;
        for (int i = 0; i < 31; i++)
          if (live[i] && (src_lvl(i) == 4'd15 || 32'(target_q) == c))
            req[src_lvl(i)] = 1'b1;
      end
      req[0] = 1'b0;
    end

    always_comb begin
      top = 4'd0;
      for (int k = 1; k < 16; k++)
        if (req[k]) top = 4'(k);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irl[4*c+:4] <= 4'd0;
      else        irl[4*c+:4] <= top;
    end

    AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[31] |=> irl[4*c+:4] == 4'd0); // R4
    AST_SOFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[31] && soft_q[c][15]) |=> irl[4*c+:4] == 4'd15); // R9
    AST_TICK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[31] && cpu_tick[c]) |=> irl[4*c+:4] >= 4'd14); // R10
    AST_ERR_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[31] && |(hw_src[30:27] & ~mask_q[30:27])) |=> irl[4*c+:4] == 4'd15); // R8
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSET) |=> (mask_q & $past(wdata)) == $past(wdata)); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCLR) |=> (mask_q & $past(wdata)) == 32'd0); // R3
  AST_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(target_q) < 32'(NCPU)); // R11
  AST_SOFT_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q[0][0] == 1'b0); // R9

endmodule

// File: tb/irq_level_ctrl_test.sv
`timescale 1ns/1ps
module irq_level_ctrl_test;
  localparam int NCPU = 2;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0;
  logic [30:0] hw_src = '0;
  logic [NCPU-1:0] cpu_tick = '0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4*NCPU-1:0] irl;

  int checks = 0, failures = 0;
  bit done = 0;

  irq_level_ctrl #(.NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .hw_src(hw_src), .cpu_tick(cpu_tick),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .irl(irl));

  always #2.5 clk = ~clk;

  // reference model
  logic [31:0] m_mask;
  int m_tgt;
  logic [15:0] m_soft [NCPU];
  int exp_lv [NCPU];
  bit model_live = 0;

  function automatic int lvl_of(int i);
    int n;
    if (i >= 27) return 15;
    if (i >= 23) return 0;
    case (i)
      14, 15: return 12;
      16: return 6;
      17: return 13;
      18: return 4;
      19: return 10;
      20: return 8;
      21: return 9;
      22: return 11;
      default: ;
    endcase
    n = (i >= 7) ? i - 6 : i + 1;
    case (n)
      1: return 2; 2: return 3; 3: return 5; 4: return 7;
      5: return 9; 6: return 11; default: return 13;
    endcase
  endfunction

  function automatic int expect_lv(int c);
    int best = 0;
    if (m_mask[31]) return 0;
    for (int k = 1; k < 16; k++) if (m_soft[c][k]) best = k;
    if (cpu_tick[c] && best < 14) best = 14;
    for (int i = 0; i < 31; i++)
      if (hw_src[i] && !m_mask[i]) begin
        int l = lvl_of(i);
        if (l != 0 && (l == 15 || m_tgt == c) && l > best) best = l;
      end
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '1; m_tgt = 0;
      for (int c = 0; c < NCPU; c++) begin m_soft[c] = '0; exp_lv[c] = 0; end
      model_live = 1;
    end else begin
      for (int c = 0; c < NCPU; c++) exp_lv[c] = expect_lv(c);
      if (wr_en) begin
        if (addr == 1) m_mask = m_mask | wdata;
        if (addr == 2) m_mask = m_mask & ~wdata;
        if (addr == 3 && wdata < NCPU) m_tgt = int'(wdata);
        for (int c = 0; c < NCPU; c++) begin
          if (addr == 4 + 2 * c) m_soft[c] = m_soft[c] | (wdata[15:0] & 16'hFFFE);
          if (addr == 5 + 2 * c) m_soft[c] = m_soft[c] & ~(wdata[15:0] & 16'hFFFE);
        end
      end
    end
  end

  // per-cycle comparison of every output level (R12)
  always @(negedge clk) begin
    if (rst_n && model_live && !done)
      for (int c = 0; c < NCPU; c++) begin
        checks++;
        if (int'(irl[4*c+:4]) != exp_lv[c]) begin
          failures++;
          $display("FAIL R12 cpu%0d level actual=%0d expected=%0d at %0t",
                   c, irl[4*c+:4], exp_lv[c], $time);
        end
      end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a); rd_en = 1;
    #1 chk(tag, rdata, exp);
    rd_en = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic lv(string tag, int c, int exp);
    #0.5 chk(tag, 32'(irl[4*c+:4]), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    lv("R1 irl cpu0", 0, 0); lv("R1 irl cpu1", 1, 0);
    rd("R1 mask", 1, 32'hFFFF_FFFF);
    rd("R1 target", 3, 0);
    rd("R1 soft0", 4, 0);
    rd("R1 soft1", 7, 0);

    // R5 raw pending with everything masked
    @(negedge clk); hw_src = '1;
    rd("R5 pending masked", 0, 32'h7FFF_FFFF);
    settle(); lv("R4 masked all", 0, 0);

    // R3 clear only master, sources still masked; zero bits no effect
    wr(2, 32'h8000_0000);
    rd("R3 clear master", 2, 32'h7FFF_FFFF);
    settle(); lv("R3 no unmasked src", 0, 0);
    wr(2, 32'h0000_4000);
    rd("R3 clear kbd", 1, 32'h7FFF_BFFF);
    settle(); lv("R6 kbd level12 tgt", 0, 12); lv("R11 non-target quiet", 1, 0);
    // R2 set back; zero bits untouched
    wr(1, 32'h0000_4000);
    rd("R2 set kbd", 1, 32'h7FFF_FFFF);
    wr(2, 32'h7FFF_FFFF);
    rd("R3 clear all", 1, 32'h0000_0000);
    wr(1, 32'h0000_0000);
    rd("R2 zero write no effect", 2, 32'h0000_0000);
    wr(2, 32'h0000_0000);
    rd("R3 zero write no effect", 1, 32'h0000_0000);

    // walk each hardware line alone (R6 R7 R8 R13)
    for (int i = 0; i < 31; i++) begin
      @(negedge clk); hw_src = 31'(1) << i;
      settle();
      lv($sformatf("R6/R7/R13 bit%0d cpu0", i), 0, lvl_of(i));
      lv($sformatf("R8/R11 bit%0d cpu1", i), 1, (lvl_of(i) == 15) ? 15 : 0);
    end
    @(negedge clk); hw_src = 31'h0000_0080; settle(); lv("R7 exp bus1 level2", 0, 2);
    @(negedge clk); hw_src = 31'h0000_0040; settle(); lv("R7 second bus7 level13", 0, 13);
    @(negedge clk); hw_src = 31'h0780_0000; settle(); lv("R13 reserved none", 0, 0);
    @(negedge clk); hw_src = 31'h0804_0000; settle();
    lv("R8 err bcast cpu1", 1, 15); lv("R12 highest cpu0", 0, 15);

    // R12 level-sensitive drop
    @(negedge clk); hw_src = 31'h0004_0000; settle(); lv("R12 scsi only", 0, 4);
    @(negedge clk); hw_src = '0;
    @(negedge clk); lv("R12 drop one cycle", 0, 0);

    // R11 target select
    wr(3, 1);
    rd("R11 target1", 3, 1);
    @(negedge clk); hw_src = 31'h0001_0000; settle();
    lv("R11 eth to cpu1", 1, 6); lv("R11 cpu0 quiet", 0, 0);
    wr(3, 5);
    rd("R11 bad target ignored", 3, 1);

    // R9 software interrupts on cpu1
    wr(6, 32'h0000_0101);
    rd("R9 soft1 bit0 dropped", 6, 32'h0000_0100);
    rd("R9 soft0 untouched", 4, 0);
    settle(); lv("R9 soft8 over eth", 1, 8); lv("R9 cpu0 no soft", 0, 0);
    wr(7, 32'h0000_0100);
    rd("R9 soft1 cleared", 7, 0);
    settle(); lv("R9 back to eth", 1, 6);

    // R10 tick
    @(negedge clk); cpu_tick = 2'b01; settle();
    lv("R10 tick cpu0", 0, 14); lv("R10 cpu1 keeps eth", 1, 6);
    wr(1, 32'h7FFF_FFFF);
    settle(); lv("R10 tick ignores src mask", 0, 14);

    // R4 master gate over soft and tick
    wr(4, 32'h0000_8000);
    settle(); lv("R9 soft15 cpu0", 0, 15);
    wr(1, 32'h8000_0000);
    settle(); lv("R4 master cpu0", 0, 0); lv("R4 master cpu1", 1, 0);
    wr(2, 32'hFFFF_FFFF);
    wr(5, 32'hFFFF);
    @(negedge clk); cpu_tick = '0; hw_src = '0;

    // random phase, checked by the model every edge
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      hw_src = 31'($urandom) & 31'($urandom);
      cpu_tick = 2'($urandom);
      wr_en = ($urandom % 4) == 0;
      addr = AW'($urandom);
      wdata = $urandom & $urandom;
      if (addr == 3) wdata = $urandom % 4;
    end
    @(negedge clk); wr_en = 0;
    settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule